// File: doc/BRIEF.md
# Stream Snapshot Capture Buffer

This block records a burst of samples from a streaming source into on-chip memory so that a host can inspect them at leisure over a simple word-addressed read bus. The streaming side and the bus side run on independent clocks with their own active-low synchronous resets. Only samples flagged valid are kept, packed at consecutive locations from location zero, until the buffer holds `DEPTH` samples. After that, input is dropped until the capture is re-armed.

A build-time parameter picks how re-arming happens. In sync mode, each sync pulse on the stream side starts a fresh capture. In free mode, the host re-arms by reading the final bus word of the buffer. A second parameter picks which part of the incoming sample is kept: the plain data field, the real part, the imaginary part, or a packed complex word. A sample wider than the 32-bit bus is spread over several consecutive bus addresses. A one-word status register reports how many samples are held and whether the buffer is full.

Top module: `snap_capture_top`

## Requirements
- R1: A sample is written only in a cycle where `s_valid` is high. Written samples go to consecutive locations, starting at location 0.
- R2: At most `DEPTH` samples are stored. Once the count reaches `DEPTH`, the full flag is set, and further valid samples change neither the stored contents nor the count until a re-arm.
- R3: In sync mode (`SYNC_REARM`=1), nothing is captured after reset until the first `s_sync` pulse. Every `s_sync` restarts filling at location 0, and a valid sample in the same cycle as `s_sync` is stored at location 0. A read of the last bus address has no effect in this mode.
- R4: In free mode (`SYNC_REARM`=0), capture is armed straight out of reset. A bus read of the last address, `DEPTH*WPS-1`, clears the count and restarts filling at location 0. Reads of any other address do not re-arm.
- R5: `WPS = ceil(DATA_W/32)`. Bus address `a` returns bits `[32*(a%WPS) +: 32]` of stored sample `a/WPS`, so the lowest part comes first. Bits above `DATA_W` read as zero.
- R6: The stored sample depends on `FIELD`:
  - `FLD_DATA` stores `s_data`.
  - `FLD_REAL` stores `s_re`.
  - `FLD_IMAG` stores `s_im`.
  - `FLD_COMPLEX` stores `{s_im[H-1:0], s_re[H-1:0]}` with `H = DATA_W/2`.
- R7: `b_ram_rdata` and `b_ram_rvalid` are updated on the first `b_clk` edge after the edge that samples `b_ram_rd`. `b_ram_rvalid` is high only in that cycle.
- R8: A status read (`b_reg_rd`) returns data one `b_clk` cycle later, with `b_reg_rvalid` high. Bit 31 is the full flag. Bits `[CNT_W-1:0]` hold the sample count. The full flag reads as 1 only when the count equals `DEPTH`.
- R9: After reset, the status reads 0 and no read-valid output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk | input | 1 | Stream clock |
| s_rst_n | input | 1 | Stream-side synchronous reset, active low |
| s_valid | input | 1 | Sample qualifier |
| s_sync | input | 1 | Capture start pulse (sync mode) |
| s_data | input | DATA_W | Plain data field |
| s_re | input | DATA_W | Real part |
| s_im | input | DATA_W | Imaginary part |
| b_clk | input | 1 | Bus clock |
| b_rst_n | input | 1 | Bus-side synchronous reset, active low |
| b_ram_rd | input | 1 | Buffer read strobe |
| b_ram_addr | input | BAW | Buffer bus-word address |
| b_ram_rdata | output | 32 | Buffer read data |
| b_ram_rvalid | output | 1 | Buffer read data valid |
| b_reg_rd | input | 1 | Status read strobe |
| b_reg_rdata | output | 32 | Status word |
| b_reg_rvalid | output | 1 | Status read data valid |

## Verification
The hardest case to reach is a re-arm in free mode. The bus-side read of the last address must cross into the stream clock domain and clear the write pointer. The cleared count must then cross back before the host can see it. The bench first fills the buffer past its capacity and confirms the overflow was dropped. It then reads every address except the last and shows that neither the count nor the contents moved. Only then does it read the final word, and it waits out both crossings before writing and reading back a new, shorter capture. The sync-mode instance runs alongside: it sees stream traffic with no sync pulse and must keep a zero count until its first pulse.

// File: rtl/snap_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the snapshot capture buffer.
// Assumes a fixed 32-bit bus word.
package snap_pkg;
    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        FLD_DATA    = 2'd0,
        FLD_COMPLEX = 2'd1,
        FLD_REAL    = 2'd2,
        FLD_IMAG    = 2'd3
    } field_sel_e;
endpackage

// File: rtl/snap_field_sel.sv
`timescale 1ns/1ps
// Chooses which part of an incoming sample gets stored.
// Assumes DATA_W >= 2 when the complex mode is selected.
module snap_field_sel
    import snap_pkg::*;
#(
    parameter int         DATA_W = 48,
    parameter field_sel_e FIELD  = FLD_DATA
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] re_i,
    input  logic [DATA_W-1:0] im_i,
    output logic [DATA_W-1:0] sel_o
);
    localparam int HALF = DATA_W / 2;

    generate
        if (FIELD == FLD_COMPLEX) begin : g_cplx
            // Pack the low halves of both parts, imaginary on top.
            assign sel_o = DATA_W'({im_i[HALF-1:0], re_i[HALF-1:0]});
        end else if (FIELD == FLD_REAL) begin : g_real
            // Keep the real part.
            assign sel_o = re_i;
        end else if (FIELD == FLD_IMAG) begin : g_imag
            // Keep the imaginary part.
            assign sel_o = im_i;
        end else begin : g_data
            // Keep the plain data field.
            assign sel_o = data_i;
        end
    endgenerate
endmodule

// File: rtl/snap_wr_ctrl.sv
`timescale 1ns/1ps
// Stream-side write pointer.
// Arms, restarts and stops the capture, and produces the RAM write strobe.
// Assumes DEPTH >= 2. A restart pulse and a valid sample in the same
// cycle store that sample at location 0.
module snap_wr_ctrl #(
    parameter int DEPTH      = 1024,
    parameter bit SYNC_REARM = 1'b0,
    localparam int AW        = $clog2(DEPTH),
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             sync_i,
    input  logic             rearm_i,
    output logic             we_o,
    output logic [AW-1:0]    waddr_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o,
    output logic             restart_o
);
    logic             armed_q;
    logic [CNT_W-1:0] ptr_q;
    logic             room;

    // Restart source depends on the re-arm mode.
    assign restart_o = SYNC_REARM ? sync_i : rearm_i;
    assign room      = (ptr_q != CNT_W'(DEPTH));

    // Write strobe and address for the current cycle.
    always_comb begin
        we_o    = valid_i && (restart_o || (armed_q && room));
        waddr_o = restart_o ? '0 : ptr_q[AW-1:0];
    end

    // Pointer and arm state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= !SYNC_REARM;
            ptr_q   <= '0;
        end else if (restart_o) begin
            armed_q <= 1'b1;
            ptr_q   <= valid_i ? CNT_W'(1) : '0;
        end else if (armed_q && room && valid_i) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign count_o = ptr_q;
    assign full_o  = !room;
endmodule

// File: rtl/snap_dc_ram.sv
`timescale 1ns/1ps
// Dual-clock sample buffer.
// Written one sample per stream cycle; read one 32-bit bus word per bus
// cycle, with a registered output one cycle after the read strobe.
// Bus words of a sample appear lowest part first, zero-padded on top.
module snap_dc_ram
    import snap_pkg::*;
#(
    parameter int DATA_W = 48,
    parameter int DEPTH  = 1024,
    localparam int WPS   = (DATA_W + BUS_W - 1) / BUS_W,
    localparam int AW    = $clog2(DEPTH),
    localparam int BAW   = $clog2(DEPTH * WPS),
    localparam int SW    = (WPS > 1) ? $clog2(WPS) : 1,
    localparam int PADW  = WPS * BUS_W
) (
    input  logic              wclk,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rd_i,
    input  logic [BAW-1:0]    raddr_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              rvalid_o
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     rd_idx;
    logic [SW-1:0]     rd_sel;
    logic [DATA_W-1:0] rd_q;
    logic [SW-1:0]     sel_q;
    logic [PADW-1:0]   wide;

    // Store one sample per write strobe.
    always_ff @(posedge wclk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    // Split the bus address into a sample index and a word select.
    always_comb begin
        rd_idx = AW'(raddr_i / BAW'(WPS));
        rd_sel = SW'(raddr_i % BAW'(WPS));
    end

    // Registered read with an aligned valid flag.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rvalid_o <= 1'b0;
            sel_q    <= '0;
            rd_q     <= '0;
        end else begin
            rvalid_o <= rd_i;
            if (rd_i) begin
                rd_q  <= mem[rd_idx];
                sel_q <= rd_sel;
            end
        end
    end

    // Zero-extend the sample and pick the addressed bus word.
    assign wide    = PADW'(rd_q);
    assign rdata_o = wide[sel_q*BUS_W +: BUS_W];
endmodule

// File: rtl/snap_stat_xfer.sv
`timescale 1ns/1ps
// Carries a multi-bit status value from the stream clock to the bus clock
// with a toggle request/acknowledge handshake.
// The held value only changes after the bus side has taken it, so the
// bus side always sees a coherent snapshot, a few cycles late.
module snap_stat_xfer #(
    parameter int W = 12
) (
    input  logic         s_clk,
    input  logic         s_rst_n,
    input  logic [W-1:0] s_val_i,
    input  logic         b_clk,
    input  logic         b_rst_n,
    output logic [W-1:0] b_val_o
);
    logic         req_t, ack_m, ack_s;
    logic [W-1:0] hold;
    logic         req_m, req_s, req_p, ack_t;

    // Bring the acknowledge toggle into the stream domain.
    always_ff @(posedge s_clk) begin
        if (!s_rst_n) begin
            ack_m <= 1'b0;
            ack_s <= 1'b0;
        end else begin
            ack_m <= ack_t;
            ack_s <= ack_m;
        end
    end

    // Load a new snapshot when the previous one was acknowledged.
    always_ff @(posedge s_clk) begin
        if (!s_rst_n) begin
            req_t <= 1'b0;
            hold  <= '0;
        end else if (ack_s == req_t) begin
            hold  <= s_val_i;
            req_t <= !req_t;
        end
    end

    // Detect a request in the bus domain, capture and acknowledge.
    always_ff @(posedge b_clk) begin
        if (!b_rst_n) begin
            req_m   <= 1'b0;
            req_s   <= 1'b0;
            req_p   <= 1'b0;
            ack_t   <= 1'b0;
            b_val_o <= '0;
        end else begin
            req_m <= req_t;
            req_s <= req_m;
            req_p <= req_s;
            ack_t <= req_p;
            if (req_s != req_p) b_val_o <= hold;
        end
    end
endmodule

// File: rtl/snap_pulse_xfer.sv
`timescale 1ns/1ps
// Moves a single-cycle event from the bus clock to the stream clock as a
// toggle, and rebuilds a one-cycle pulse on the stream side.
// Assumes events are spaced further apart than the synchroniser delay.
module snap_pulse_xfer (
    input  logic b_clk,
    input  logic b_rst_n,
    input  logic b_evt_i,
    input  logic s_clk,
    input  logic s_rst_n,
    output logic s_pulse_o
);
    logic tog_q;
    logic s_m, s_s, s_p;

    // Flip the toggle on every event.
    always_ff @(posedge b_clk) begin
        if (!b_rst_n) tog_q <= 1'b0;
        else          tog_q <= tog_q ^ b_evt_i;
    end

    // Synchronise the toggle and keep the previous value.
    always_ff @(posedge s_clk) begin
        if (!s_rst_n) begin
            s_m <= 1'b0;
            s_s <= 1'b0;
            s_p <= 1'b0;
        end else begin
            s_m <= tog_q;
            s_s <= s_m;
            s_p <= s_s;
        end
    end

    assign s_pulse_o = s_s ^ s_p;
endmodule

// File: rtl/snap_capture_top.sv
`timescale 1ns/1ps
// Stream snapshot capture buffer.
// Records valid samples into a dual-clock buffer for bus read-back and
// exposes a status word (bit 31 full, low bits sample count).
// SYNC_REARM selects re-arm by s_sync or by a bus read of the last word.
// Assumes DEPTH >= 2 and $clog2(DEPTH+1) <= 31.
module snap_capture_top
    import snap_pkg::*;
#(
    parameter int         DATA_W     = 48,
    parameter int         DEPTH      = 1024,
    parameter field_sel_e FIELD      = FLD_DATA,
    parameter bit         SYNC_REARM = 1'b0,
    localparam int        WPS        = (DATA_W + BUS_W - 1) / BUS_W,
    localparam int        BAW        = $clog2(DEPTH * WPS)
) (
    input  logic              s_clk,
    input  logic              s_rst_n,
    input  logic              s_valid,
    input  logic              s_sync,
    input  logic [DATA_W-1:0] s_data,
    input  logic [DATA_W-1:0] s_re,
    input  logic [DATA_W-1:0] s_im,
    input  logic              b_clk,
    input  logic              b_rst_n,
    input  logic              b_ram_rd,
    input  logic [BAW-1:0]    b_ram_addr,
    output logic [31:0]       b_ram_rdata,
    output logic              b_ram_rvalid,
    input  logic              b_reg_rd,
    output logic [31:0]       b_reg_rdata,
    output logic              b_reg_rvalid
);
    localparam int AW       = $clog2(DEPTH);
    localparam int CNT_W    = $clog2(DEPTH + 1);
    localparam int LAST_ADR = DEPTH * WPS - 1;

    logic [DATA_W-1:0] s_sample;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [CNT_W-1:0]  wr_count;
    logic              wr_full;
    logic              wr_restart;
    logic              s_rearm_pulse;
    logic [CNT_W:0]    stat_b;

    snap_field_sel #(
        .DATA_W (DATA_W),
        .FIELD  (FIELD)
    ) u_sel (
        .data_i (s_data),
        .re_i   (s_re),
        .im_i   (s_im),
        .sel_o  (s_sample)
    );

    snap_wr_ctrl #(
        .DEPTH      (DEPTH),
        .SYNC_REARM (SYNC_REARM)
    ) u_ctrl (
        .clk       (s_clk),
        .rst_n     (s_rst_n),
        .valid_i   (s_valid),
        .sync_i    (s_sync),
        .rearm_i   (s_rearm_pulse),
        .we_o      (mem_we),
        .waddr_o   (mem_waddr),
        .count_o   (wr_count),
        .full_o    (wr_full),
        .restart_o (wr_restart)
    );

    snap_dc_ram #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_ram (
        .wclk     (s_clk),
        .we_i     (mem_we),
        .waddr_i  (mem_waddr),
        .wdata_i  (s_sample),
        .rclk     (b_clk),
        .rrst_n   (b_rst_n),
        .rd_i     (b_ram_rd),
        .raddr_i  (b_ram_addr),
        .rdata_o  (b_ram_rdata),
        .rvalid_o (b_ram_rvalid)
    );

    snap_stat_xfer #(
        .W (CNT_W + 1)
    ) u_stat (
        .s_clk   (s_clk),
        .s_rst_n (s_rst_n),
        .s_val_i ({wr_full, wr_count}),
        .b_clk   (b_clk),
        .b_rst_n (b_rst_n),
        .b_val_o (stat_b)
    );

    generate
        if (SYNC_REARM) begin : g_sync_rearm
            // The stream sync pulse re-arms; the bus has no say.
            assign s_rearm_pulse = 1'b0;
        end else begin : g_read_rearm
            logic last_rd;
            // A read of the final bus word asks for a new capture.
            assign last_rd = b_ram_rd && (b_ram_addr == BAW'(LAST_ADR));

            snap_pulse_xfer u_rearm (
                .b_clk     (b_clk),
                .b_rst_n   (b_rst_n),
                .b_evt_i   (last_rd),
                .s_clk     (s_clk),
                .s_rst_n   (s_rst_n),
                .s_pulse_o (s_rearm_pulse)
            );
        end
    endgenerate

    // Status register read port, one-cycle latency.
    always_ff @(posedge b_clk) begin
        if (!b_rst_n) begin
            b_reg_rvalid <= 1'b0;
            b_reg_rdata  <= '0;
        end else begin
            b_reg_rvalid <= b_reg_rd;
            if (b_reg_rd)
                b_reg_rdata <= {stat_b[CNT_W], {(31-CNT_W){1'b0}}, stat_b[CNT_W-1:0]};
        end
    end
endmodule

// File: rtl/snap_capture_chk.sv
`timescale 1ns/1ps
// Protocol checker for snap_capture_top, attached with bind.
// Watches the write strobe, the write pointer and both read ports.
module snap_capture_chk #(
    parameter int DEPTH = 1024,
    parameter int CNT_W = 11
) (
    input logic             s_clk,
    input logic             s_rst_n,
    input logic             s_valid,
    input logic             mem_we,
    input logic             wr_restart,
    input logic [CNT_W-1:0] wr_count,
    input logic             b_clk,
    input logic             b_rst_n,
    input logic             b_ram_rd,
    input logic             b_ram_rvalid,
    input logic             b_reg_rd,
    input logic             b_reg_rvalid,
    input logic [31:0]      b_reg_rdata
);
    assert_no_write_when_idle_R1: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        !s_valid |-> !mem_we);

    assert_write_advances_R1: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        (mem_we && !wr_restart) |=> (wr_count == $past(wr_count) + CNT_W'(1)));

    assert_no_overflow_R2: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        wr_count <= CNT_W'(DEPTH));

    assert_ram_latency_R7: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        b_ram_rd |=> b_ram_rvalid);

    assert_ram_valid_only_R7: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        !b_ram_rd |=> !b_ram_rvalid);

    assert_reg_latency_R8: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        b_reg_rd |=> b_reg_rvalid);

    assert_full_means_depth_R8: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        (b_reg_rvalid && b_reg_rdata[31]) |-> (b_reg_rdata[CNT_W-1:0] == CNT_W'(DEPTH)));
endmodule

bind snap_capture_top snap_capture_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .s_clk        (s_clk),
    .s_rst_n      (s_rst_n),
    .s_valid      (s_valid),
    .mem_we       (mem_we),
    .wr_restart   (wr_restart),
    .wr_count     (wr_count),
    .b_clk        (b_clk),
    .b_rst_n      (b_rst_n),
    .b_ram_rd     (b_ram_rd),
    .b_ram_rvalid (b_ram_rvalid),
    .b_reg_rd     (b_reg_rd),
    .b_reg_rvalid (b_reg_rvalid),
    .b_reg_rdata  (b_reg_rdata)
);

// File: tb/snap_capture_top_bench.sv
`timescale 1ns/1ps
module snap_capture_top_bench;
    import snap_pkg::*;

    logic s_clk = 1'b0;
    logic b_clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 s_clk = ~s_clk;   // 125 MHz stream clock
    always #5 b_clk = ~b_clk;   // bus clock

    logic        sv = 1'b0, ss = 1'b0;
    logic [47:0] sd = '0, sre = '0, sim = '0;

    logic        a_rd = 1'b0, a_srd = 1'b0;  logic [3:0] a_addr = '0;
    logic        b_rd = 1'b0, b_srd = 1'b0;  logic [2:0] b_addr = '0;
    logic        c_rd = 1'b0, c_srd = 1'b0;  logic [2:0] c_addr = '0;
    logic [31:0] a_rdata, b_rdata, c_rdata, d_rdata, a_sdata, b_sdata, c_sdata, d_sdata;
    logic        a_rv, b_rv, c_rv, d_rv, a_sv, b_sv, c_sv, d_sv;

    int checks = 0;
    int fails  = 0;

    // A: free mode, 48-bit plain data, two bus words per sample
    snap_capture_top #(.DATA_W(48), .DEPTH(8), .FIELD(FLD_DATA), .SYNC_REARM(1'b0)) u_snap_capture_top (
        .s_clk(s_clk), .s_rst_n(rst_n), .s_valid(sv), .s_sync(ss),
        .s_data(sd), .s_re(sre), .s_im(sim),
        .b_clk(b_clk), .b_rst_n(rst_n), .b_ram_rd(a_rd), .b_ram_addr(a_addr),
        .b_ram_rdata(a_rdata), .b_ram_rvalid(a_rv),
        .b_reg_rd(a_srd), .b_reg_rdata(a_sdata), .b_reg_rvalid(a_sv));

    // B: sync mode, 32-bit packed complex
    snap_capture_top #(.DATA_W(32), .DEPTH(8), .FIELD(FLD_COMPLEX), .SYNC_REARM(1'b1)) u_snap_capture_top_sync (
        .s_clk(s_clk), .s_rst_n(rst_n), .s_valid(sv), .s_sync(ss),
        .s_data(sd[31:0]), .s_re(sre[31:0]), .s_im(sim[31:0]),
        .b_clk(b_clk), .b_rst_n(rst_n), .b_ram_rd(b_rd), .b_ram_addr(b_addr),
        .b_ram_rdata(b_rdata), .b_ram_rvalid(b_rv),
        .b_reg_rd(b_srd), .b_reg_rdata(b_sdata), .b_reg_rvalid(b_sv));

    // C and D: free mode, 16-bit real and imaginary, shared bus strobes
    snap_capture_top #(.DATA_W(16), .DEPTH(8), .FIELD(FLD_REAL), .SYNC_REARM(1'b0)) u_snap_capture_top_re (
        .s_clk(s_clk), .s_rst_n(rst_n), .s_valid(sv), .s_sync(ss),
        .s_data(sd[15:0]), .s_re(sre[15:0]), .s_im(sim[15:0]),
        .b_clk(b_clk), .b_rst_n(rst_n), .b_ram_rd(c_rd), .b_ram_addr(c_addr),
        .b_ram_rdata(c_rdata), .b_ram_rvalid(c_rv),
        .b_reg_rd(c_srd), .b_reg_rdata(c_sdata), .b_reg_rvalid(c_sv));

    snap_capture_top #(.DATA_W(16), .DEPTH(8), .FIELD(FLD_IMAG), .SYNC_REARM(1'b0)) u_snap_capture_top_im (
        .s_clk(s_clk), .s_rst_n(rst_n), .s_valid(sv), .s_sync(ss),
        .s_data(sd[15:0]), .s_re(sre[15:0]), .s_im(sim[15:0]),
        .b_clk(b_clk), .b_rst_n(rst_n), .b_ram_rd(c_rd), .b_ram_addr(c_addr),
        .b_ram_rdata(d_rdata), .b_ram_rvalid(d_rv),
        .b_reg_rd(c_srd), .b_reg_rdata(d_sdata), .b_reg_rvalid(d_sv));

    function automatic logic [47:0] samp(input int k);
        return {16'hC000 + 16'(k), 32'h1234_0000 + 32'(k) * 32'h0101_0011};
    endfunction
    function automatic logic [47:0] f_re(input logic [47:0] d);
        return d + 48'h0000_0000_0111;
    endfunction
    function automatic logic [47:0] f_im(input logic [47:0] d);
        return d ^ 48'h5A5A_0F0F_3C3C;
    endfunction
    function automatic logic [31:0] cplx(input logic [47:0] d);
        logic [47:0] r, i;
        r = f_re(d);
        i = f_im(d);
        return {i[15:0], r[15:0]};
    endfunction
    function automatic logic [31:0] a_word(input int adr, input logic [47:0] d);
        return (adr % 2 == 0) ? d[31:0] : {16'h0000, d[47:32]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic st(input logic v, input logic sy, input logic [47:0] d);
        @(negedge s_clk);
        sv = v; ss = sy; sd = d; sre = f_re(d); sim = f_im(d);
    endtask

    task automatic idle_bus(input int n);
        repeat (n) @(negedge b_clk);
    endtask

    // which: 0 = A, 1 = B, 2 = C, 3 = D (C and D share strobes)
    task automatic bus_rd(input int which, input int adr, output logic [31:0] dat, output logic vld);
        @(negedge b_clk);
        case (which)
            0:       begin a_rd = 1'b1; a_addr = 4'(adr); end
            1:       begin b_rd = 1'b1; b_addr = 3'(adr); end
            default: begin c_rd = 1'b1; c_addr = 3'(adr); end
        endcase
        @(negedge b_clk);
        a_rd = 1'b0; b_rd = 1'b0; c_rd = 1'b0;
        case (which)
            0:       begin dat = a_rdata; vld = a_rv; end
            1:       begin dat = b_rdata; vld = b_rv; end
            2:       begin dat = c_rdata; vld = c_rv; end
            default: begin dat = d_rdata; vld = d_rv; end
        endcase
    endtask

    task automatic stat_rd(input int which, output logic [31:0] dat, output logic vld);
        @(negedge b_clk);
        case (which)
            0:       a_srd = 1'b1;
            1:       b_srd = 1'b1;
            default: c_srd = 1'b1;
        endcase
        @(negedge b_clk);
        a_srd = 1'b0; b_srd = 1'b0; c_srd = 1'b0;
        case (which)
            0:       begin dat = a_sdata; vld = a_sv; end
            1:       begin dat = b_sdata; vld = b_sv; end
            2:       begin dat = c_sdata; vld = c_sv; end
            default: begin dat = d_sdata; vld = d_sv; end
        endcase
    endtask

    task automatic t_reset();
        logic [31:0] d; logic v;
        chk("R9 ram rvalid idle", {31'b0, a_rv | b_rv | c_rv | d_rv}, 32'h0);
        stat_rd(0, d, v); chk("R9 status A", d, 32'h0); chk("R8 status valid", {31'b0, v}, 32'h1);
        stat_rd(1, d, v); chk("R9 status B", d, 32'h0);
        stat_rd(2, d, v); chk("R9 status C", d, 32'h0);
    endtask

    // Free mode fill past capacity with gaps; sync instance must stay empty.
    task automatic t_nonsync_capture();
        logic [31:0] d; logic v;
        for (int k = 0; k < 11; k++) begin
            st(1'b1, 1'b0, samp(k));
            st(1'b0, 1'b0, 48'hBAD0_0000_0000 + 48'(k));
        end
        st(1'b0, 1'b0, '0);
        idle_bus(40);
        stat_rd(0, d, v); chk("R2 full after overfill", d, 32'h8000_0008);
        stat_rd(1, d, v); chk("R3 no capture before sync", d, 32'h0);
        for (int a = 0; a < 15; a++) begin
            bus_rd(0, a, d, v);
            chk("R5 split words / R1 order", d, a_word(a, samp(a / 2)));
            if (a == 0) chk("R7 rvalid with data", {31'b0, v}, 32'h1);
        end
        @(negedge b_clk);
        chk("R7 rvalid drops", {31'b0, a_rv}, 32'h0);
        st(1'b1, 1'b0, samp(20));
        st(1'b1, 1'b0, samp(21));
        st(1'b0, 1'b0, '0);
        idle_bus(40);
        stat_rd(0, d, v); chk("R4 no re-arm from other reads", d, 32'h8000_0008);
        bus_rd(0, 0, d, v); chk("R2 extra samples ignored", d, samp(0)[31:0]);
    endtask

    task automatic t_nonsync_rearm();
        logic [31:0] d; logic v;
        bus_rd(0, 15, d, v); chk("R5 last word", d, a_word(15, samp(7)));
        idle_bus(40);
        stat_rd(0, d, v); chk("R4 re-arm clears count", d, 32'h0);
        for (int k = 30; k < 33; k++) st(1'b1, 1'b0, samp(k));
        st(1'b0, 1'b0, '0);
        idle_bus(40);
        stat_rd(0, d, v); chk("R4 new capture count", d, 32'h3);
        for (int a = 0; a < 6; a++) begin
            bus_rd(0, a, d, v);
            chk("R4 new capture data", d, a_word(a, samp(30 + a / 2)));
        end
    endtask

    task automatic t_field_modes();
        logic [31:0] d; logic v;
        logic [47:0] x;
        for (int k = 0; k < 8; k++) begin
            x = f_re(samp(k));
            bus_rd(2, k, d, v); chk("R6 real field", d, {16'h0, x[15:0]});
            x = f_im(samp(k));
            bus_rd(3, k, d, v); chk("R6 imaginary field", d, {16'h0, x[15:0]});
        end
        stat_rd(2, d, v); chk("R2 real instance full", d, 32'h8000_0008);
    endtask

    task automatic t_sync_start();
        logic [31:0] d; logic v;
        st(1'b1, 1'b1, samp(40));
        for (int k = 41; k < 45; k++) begin
            st(1'b0, 1'b0, 48'h0BAD_0000_0000);
            st(1'b1, 1'b0, samp(k));
        end
        st(1'b0, 1'b0, '0);
        idle_bus(40);
        stat_rd(1, d, v); chk("R3 capture from sync", d, 32'h5);
        for (int a = 0; a < 5; a++) begin
            bus_rd(1, a, d, v); chk("R6 complex packing / R3 sync sample at 0", d, cplx(samp(40 + a)));
        end
    endtask

    task automatic t_sync_restart();
        logic [31:0] d; logic v;
        st(1'b0, 1'b1, '0);
        st(1'b1, 1'b0, samp(50));
        st(1'b1, 1'b0, samp(51));
        st(1'b0, 1'b0, '0);
        idle_bus(40);
        stat_rd(1, d, v); chk("R3 restart count", d, 32'h2);
        bus_rd(1, 0, d, v); chk("R3 restart at location 0", d, cplx(samp(50)));
        bus_rd(1, 1, d, v); chk("R1 next location", d, cplx(samp(51)));
    endtask

    task automatic t_sync_full();
        logic [31:0] d; logic v;
        st(1'b1, 1'b1, samp(60));
        for (int k = 61; k < 70; k++) st(1'b1, 1'b0, samp(k));
        st(1'b0, 1'b0, '0);
        idle_bus(40);
        stat_rd(1, d, v); chk("R2 sync instance full", d, 32'h8000_0008);
        bus_rd(1, 7, d, v); chk("R2 last stored sample", d, cplx(samp(67)));
        idle_bus(10);
        st(1'b1, 1'b0, samp(70));
        st(1'b1, 1'b0, samp(71));
        st(1'b0, 1'b0, '0);
        idle_bus(40);
        stat_rd(1, d, v); chk("R3 last-word read ignored in sync mode", d, 32'h8000_0008);
        bus_rd(1, 0, d, v); chk("R3 contents kept", d, cplx(samp(60)));
    endtask

    bit done = 1'b0;

    initial begin
        repeat (5) @(negedge s_clk);
        rst_n = 1'b1;
        repeat (2) @(negedge b_clk);
        t_reset();
        t_nonsync_capture();
        t_field_modes();
        t_nonsync_rearm();
        t_sync_start();
        t_sync_restart();
        t_sync_full();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int n = 0; n < 100000; n++) begin
            @(posedge s_clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule